// File: doc/BRIEF.md
# Video DMA Instruction Sequencer

This block walks a small program of one- and two-DWORD instructions held in memory and uses it to steer a stream of pixel DWORDs from a FIFO into target memory. Write instructions turn FIFO words into memory write requests with byte enables. Skip instructions consume FIFO words and only move the address counter. A jump reloads the program counter, so a field program can loop or chain into another one while pixels keep flowing. A sync instruction throws FIFO words away until one arrives whose 4-bit status tag matches the code it names. This lines the program up with field and frame boundaries.

Every line is bracketed by start-of-line and end-of-line marks in the instructions, and the FIFO flags the last word of each line. If that flag comes before the instruction marked end-of-line, the rest of the line's instructions are dropped. Reserved or unused opcodes, bad sync codes, nonzero reserved bits and a write-continue that claims to start a line all count as programming errors. Each of them sets a sticky interrupt and freezes the sequencer until software takes the enable low.

Top module: `vdma_seq`

## Requirements
- R1: The opcode is DWORD0 bits [31:28]: 0001 write (two DWORDs, DWORD1 is the byte target address), 1001 write-continue, 0010 skip, 0111 jump (two DWORDs, DWORD1 is the new program counter), 1000 sync. For the three data opcodes, bit 27 is SOL, bit 26 is EOL and bits [CW-1:0] are the byte count. For sync, bits [3:0] are the status code.
- R2: A write pops one FIFO word per memory write and issues each write at the address counter with the popped data. Byte enables are 4'hF while four or more bytes remain. The final partial word gets the low 1, 2 or 3 enables. The counter advances by the bytes written.
- R3: Write-continue starts from the current address counter. Write-continue with SOL set is an error.
- R4: Skip pops ceil(count/4) FIFO words, issues no writes, and advances the address counter by the count.
- R5: Jump loads the program counter from DWORD1 [PCW-1:0], and fetching resumes there.
- R6: Sync pops and discards FIFO words up to and including the first word whose status tag equals its code. The next instruction then runs.
- R7: Sync codes outside {1,2,3,6,7,14} are errors, and no FIFO word is popped.
- R8: Any opcode other than the five in R1 (including 0000 and 1111) sets the error interrupt. After that there are no fetches, pops or writes until the enable is taken low.
- R9: A FIFO word flagged EOL ends the current instruction once that word is handled. If the instruction lacks its EOL bit, the following data instructions are fetched and discarded up to and including the next one that carries EOL. Discarded instructions cause no pops and no writes, and leave the address counter unchanged.
- R10: The error interrupt stays set until the clear input is raised. A new error in the same cycle as a clear leaves it set.
- R11: While the enable is low there are no fetches, pops or writes, and the program counter returns to START_PC. Raising the enable fetches from START_PC first.
- R12: Fetch addresses are DWORD indices that advance by one per fetched DWORD. Nonzero reserved bits are errors: DWORD0 bits [25:CW] of data opcodes, [27:0] of jump, [27:4] of sync, and jump DWORD1 above PCW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Program enable |
| irq_clr | input | 1 | Clears the error interrupt |
| if_req | output | 1 | Instruction fetch request |
| if_addr | output | PCW | DWORD index being fetched |
| if_vld | input | 1 | Fetch data valid |
| if_data | input | 32 | Fetched DWORD |
| fifo_vld | input | 1 | FIFO word available |
| fifo_data | input | 32 | FIFO pixel DWORD |
| fifo_eol | input | 1 | Word is the last of its line |
| fifo_tag | input | 4 | Status tag of the word |
| fifo_rd | output | 1 | Pop the FIFO word |
| wr_vld | output | 1 | Memory write request |
| wr_addr | output | AW | Byte target address |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte enables |
| wr_rdy | input | 1 | Memory accepts the write |
| irq_err | output | 1 | Sticky instruction-error interrupt |

## Verification
Two events can land on one edge. The first is a FIFO end-of-line flag arriving on a word that is also being written. The bench covers this with a write marked EOL whose first word already carries the flag, and with an unmarked write whose second word carries it. It then judges, from the write log and the address of a later write-continue, whether the word was written, whether the instruction ended there and whether the drop mode was entered. The second is an error being raised in the same cycle as the interrupt clear. The bench holds the clear high through a run that ends on an illegal opcode. The interrupt must still be seen for one cycle and must fall afterwards, while the sequencer stays frozen.

// File: rtl/vdma_seq.sv
module vdma_seq #(
  parameter int PCW = 10,
  parameter int CW = 12,
  parameter int AW = 32,
  parameter logic [PCW-1:0] START_PC = '0,
  parameter logic [15:0] TAG_OK = 16'h40CE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic           irq_clr,
  output logic           if_req,
  output logic [PCW-1:0] if_addr,
  input  logic           if_vld,
  input  logic [31:0]    if_data,
  input  logic           fifo_vld,
  input  logic [31:0]    fifo_data,
  input  logic           fifo_eol,
  input  logic [3:0]     fifo_tag,
  output logic           fifo_rd,
  output logic           wr_vld,
  output logic [AW-1:0]  wr_addr,
  output logic [31:0]    wr_data,
  output logic [3:0]     wr_be,
  input  logic           wr_rdy,
  output logic           irq_err
);
  localparam logic [3:0] OP_WR   = 4'h1;
  localparam logic [3:0] OP_SKIP = 4'h2;
  localparam logic [3:0] OP_JMP  = 4'h7;
  localparam logic [3:0] OP_SYNC = 4'h8;
  localparam logic [3:0] OP_WRC  = 4'h9;
  localparam logic [CW-1:0] FOUR = CW'(4);

  typedef enum logic [2:0] {ST_IDLE, ST_OP, ST_ARG, ST_SYNC, ST_MOVE, ST_HALT} st_t;

  st_t           st;
  logic [PCW-1:0] pc;
  logic [AW-1:0] acnt;
  logic [CW-1:0] rem;
  logic [3:0]    op, tag;
  logic          eol_q, drop, irq_q;

  logic [3:0]    d_op;
  logic          d_data, d_rsv, d_bad, arg_bad, err_set, moving;
  logic [CW-1:0] step;

  assign d_op   = if_data[31:28];
  assign d_data = (d_op == OP_WR) || (d_op == OP_WRC) || (d_op == OP_SKIP);
  assign d_rsv  = d_data ? ((if_data[25:0] >> CW) != '0) :
                  (d_op == OP_JMP)  ? (if_data[27:0] != '0) :
                  (d_op == OP_SYNC) ? (if_data[27:4] != '0) : 1'b0;
  assign d_bad  = !(d_data || d_op == OP_JMP || d_op == OP_SYNC) || d_rsv ||
                  (d_op == OP_WRC && if_data[27]) ||
                  (d_op == OP_SYNC && !TAG_OK[if_data[3:0]]);
  assign arg_bad = (if_data >> PCW) != '0;
  assign err_set = run_en && if_vld &&
                   ((st == ST_OP && d_bad) || (st == ST_ARG && op == OP_JMP && arg_bad));

  assign step   = (rem > FOUR) ? FOUR : rem;
  assign moving = run_en && st == ST_MOVE && rem != '0 && fifo_vld;

  assign if_req  = run_en && (st == ST_OP || st == ST_ARG);
  assign if_addr = pc;
  assign wr_vld  = moving && op != OP_SKIP;
  assign wr_addr = acnt;
  assign wr_data = fifo_data;
  assign wr_be   = (rem >= FOUR) ? 4'hF : (rem == CW'(3)) ? 4'h7 :
                   (rem == CW'(2)) ? 4'h3 : 4'h1;
  assign fifo_rd = (moving && (op == OP_SKIP || wr_rdy)) ||
                   (run_en && st == ST_SYNC && fifo_vld);
  assign irq_err = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      pc <= START_PC;
      acnt <= '0;
      rem <= '0;
      op <= '0;
      tag <= '0;
      eol_q <= 1'b0;
      drop <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (err_set) irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;

      if (!run_en) begin
        st <= ST_IDLE;
        pc <= START_PC;
        drop <= 1'b0;
        rem <= '0;
      end else begin
        unique case (st)
          ST_IDLE: st <= ST_OP;
          ST_OP: if (if_vld) begin
            pc <= pc + 1'b1;
            op <= d_op;
            eol_q <= if_data[26];
            rem <= if_data[CW-1:0];
            tag <= if_data[3:0];
            if (d_bad) st <= ST_HALT;
            else if (d_op == OP_WR || d_op == OP_JMP) st <= ST_ARG;
            else if (d_op == OP_SYNC) st <= ST_SYNC;
            else if (drop) begin
              if (if_data[26]) drop <= 1'b0;
            end else st <= ST_MOVE;
          end
          ST_ARG: if (if_vld) begin
            pc <= pc + 1'b1;
            if (op == OP_JMP) begin
              if (arg_bad) st <= ST_HALT;
              else begin
                pc <= if_data[PCW-1:0];
                st <= ST_OP;
              end
            end else if (drop) begin
              if (eol_q) drop <= 1'b0;
              st <= ST_OP;
            end else begin
              acnt <= if_data[AW-1:0];
              st <= ST_MOVE;
            end
          end
          ST_MOVE: begin
            if (rem == '0) st <= ST_OP;
            else if (fifo_rd) begin
              acnt <= acnt + AW'(step);
              rem <= rem - step;
              if (fifo_eol) begin
                rem <= '0;
                st <= ST_OP;
                if (!eol_q) drop <= 1'b1;
              end else if (rem == step) st <= ST_OP;
            end
          end
          ST_SYNC: if (fifo_rd && fifo_tag == tag) st <= ST_OP;
          default: st <= ST_HALT;
        endcase
      end
    end
  end

  // R2
  write_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld && wr_rdy |-> fifo_rd);

  // R2
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> (wr_be == 4'h1 || wr_be == 4'h3 || wr_be == 4'h7 || wr_be == 4'hF));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_rdy && !fifo_eol && wr_be == 4'hF) |=>
      (!wr_vld || wr_addr == $past(wr_addr) + AW'(4)));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_HALT |-> !fifo_rd && !if_req && !wr_vld);

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err && !irq_clr |=> irq_err);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !fifo_rd && !wr_vld);

  // R12
  fetch_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && if_vld && !err_set && st == ST_OP && d_op != OP_JMP) |=>
      (if_addr == $past(if_addr) + 1'b1));
endmodule

// File: tb/sim_vdma_seq.sv
module sim_vdma_seq;
  logic clk = 0, rst_n = 0, run_en = 0, irq_clr = 0, tb_clr = 0, stall = 0;
  logic if_req, if_vld, fifo_vld, fifo_eol, fifo_rd, wr_vld, wr_rdy, irq_err;
  logic [9:0] if_addr;
  logic [31:0] if_data, fifo_data, wr_data, wr_addr;
  logic [3:0] fifo_tag, wr_be;
  logic [31:0] imem [64];
  logic [31:0] fd [32];
  logic fe [32];
  logic [3:0] ft [32];
  int flen = 0, fptr = 0, nlog = 0, nfl = 0;
  logic [31:0] la [32], ldat [32];
  logic [3:0] lbe [32];
  logic [9:0] fl [16];
  logic saw_irq = 0;
  logic [7:0] cyc = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  assign if_vld = if_req;
  assign if_data = imem[if_addr[5:0]];
  assign fifo_vld = fptr < flen;
  assign fifo_data = fd[fptr[4:0]];
  assign fifo_eol = fe[fptr[4:0]];
  assign fifo_tag = ft[fptr[4:0]];
  assign wr_rdy = !stall || cyc[0];

  vdma_seq u0 (.clk(clk), .rst_n(rst_n), .run_en(run_en), .irq_clr(irq_clr),
    .if_req(if_req), .if_addr(if_addr), .if_vld(if_vld), .if_data(if_data),
    .fifo_vld(fifo_vld), .fifo_data(fifo_data), .fifo_eol(fifo_eol), .fifo_tag(fifo_tag),
    .fifo_rd(fifo_rd), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .wr_rdy(wr_rdy), .irq_err(irq_err));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tb_clr) begin
      fptr <= 0; nlog <= 0; nfl <= 0; saw_irq <= 0;
    end else begin
      if (fifo_rd && fifo_vld) fptr <= fptr + 1;
      if (wr_vld && wr_rdy && nlog < 32) begin
        la[nlog] <= wr_addr; ldat[nlog] <= wr_data; lbe[nlog] <= wr_be; nlog <= nlog + 1;
      end
      if (if_req && if_vld && nfl < 16) begin
        fl[nfl] <= if_addr; nfl <= nfl + 1;
      end
      if (irq_err) saw_irq <= 1;
    end
  end

  function automatic logic [31:0] ins(logic [3:0] o, bit s, bit e, int c);
    return {o, s, e, 14'd0, 12'(c)};
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) imem[i] = 32'd0;
    for (int i = 0; i < 32; i++) begin fd[i] = 0; fe[i] = 0; ft[i] = 0; end
    flen = 0; stall = 0;
  endtask

  task automatic push(logic [31:0] d, bit e, logic [3:0] t);
    fd[flen] = d; fe[flen] = e; ft[flen] = t; flen++;
  endtask

  task automatic run_prog();
    @(negedge clk); tb_clr = 1; @(negedge clk); tb_clr = 0; run_en = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq_err || saw_irq) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic stop_prog();
    run_en = 0; irq_clr = 1; @(negedge clk); irq_clr = 0; @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_prog();
    repeat (3) @(negedge clk);
    // R11 R10 reset state
    chk("R11", "reset if_req", if_req, 0);
    chk("R11", "reset fifo_rd", fifo_rd, 0);
    chk("R11", "reset wr_vld", wr_vld, 0);
    chk("R10", "reset irq", irq_err, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R11", "disabled no fetch", if_req, 0);

    // R1 R2 R3 write sweep over byte counts, then write-continue at counter
    for (int n = 1; n <= 12; n++) begin
      int nw;
      logic [31:0] base;
      clear_prog();
      stall = n[0];
      nw = (n + 3) / 4;
      base = 32'h1000 + 32'(n * 64);
      imem[0] = ins(4'h1, 1, 1, n); imem[1] = base;
      imem[2] = ins(4'h9, 0, 1, 4);
      for (int k = 0; k < nw; k++) push(32'hA000_0000 + 32'(n * 16 + k), k == nw - 1, 0);
      push(32'hBEEF_0000 + 32'(n), 1, 0);
      run_prog();
      chk("R2", "write count", nlog, nw + 1);
      chk("R4", "pops", fptr, nw + 1);
      for (int k = 0; k < nw; k++) begin
        int r;
        r = n - 4 * k;
        chk("R1", "write addr", la[k], base + 32'(4 * k));
        chk("R2", "write data", ldat[k], 32'hA000_0000 + 32'(n * 16 + k));
        chk("R2", "write be", lbe[k], r >= 4 ? 4'hF : 4'((1 << r) - 1));
      end
      chk("R3", "continue addr", la[nw], base + 32'(n));
      chk("R3", "continue data", ldat[nw], 32'hBEEF_0000 + 32'(n));
      chk("R8", "end marker irq", irq_err, 1);
      repeat (8) @(negedge clk);
      chk("R10", "irq sticky", irq_err, 1);
      chk("R8", "halted no fetch", if_req, 0);
      stop_prog();
    end

    // R4 skip advances counter without writes
    clear_prog();
    imem[0] = ins(4'h1, 1, 0, 4); imem[1] = 32'h2000;
    imem[2] = ins(4'h2, 0, 0, 10);
    imem[3] = ins(4'h9, 0, 1, 4);
    for (int k = 0; k < 5; k++) push(32'hC0 + 32'(k), k == 4, 0);
    run_prog();
    chk("R4", "skip writes", nlog, 2);
    chk("R4", "skip pops", fptr, 5);
    chk("R4", "after skip addr", la[1], 32'h200E);
    chk("R4", "after skip data", ldat[1], 32'hC4);
    stop_prog();

    // R6 R7 sync code sweep
    for (int c = 0; c < 16; c++) begin
      bit ok;
      ok = (c == 1) || (c == 2) || (c == 3) || (c == 6) || (c == 7) || (c == 14);
      clear_prog();
      imem[0] = {4'h8, 24'd0, 4'(c)};
      imem[1] = ins(4'h1, 1, 1, 4); imem[2] = 32'h3000;
      push(32'h11, 0, 4'(c + 1)); push(32'h22, 0, 4'(c + 2)); push(32'h33, 0, 4'(c));
      push(32'h44, 1, 4'(c));
      run_prog();
      if (ok) begin
        chk("R6", "sync pops", fptr, 4);
        chk("R6", "sync writes", nlog, 1);
        chk("R6", "sync data", ldat[0], 32'h44);
      end else begin
        chk("R7", "bad code irq", irq_err, 1);
        chk("R7", "bad code pops", fptr, 0);
        chk("R7", "bad code writes", nlog, 0);
      end
      stop_prog();
    end

    // R8 illegal opcode sweep
    for (int o = 0; o < 16; o++) begin
      if (o == 1 || o == 2 || o == 7 || o == 8 || o == 9) continue;
      clear_prog();
      imem[0] = {4'(o), 28'd0};
      push(32'h55, 0, 0); push(32'h66, 1, 0);
      run_prog();
      chk("R8", "illegal irq", irq_err, 1);
      chk("R8", "illegal pops", fptr, 0);
      chk("R8", "illegal fetches", nfl, 1);
      stop_prog();
    end

    // R3 write-continue with SOL is an error
    clear_prog();
    imem[0] = ins(4'h9, 1, 1, 4);
    push(32'h77, 1, 0);
    run_prog();
    chk("R3", "writec sol irq", irq_err, 1);
    chk("R3", "writec sol pops", fptr, 0);
    chk("R3", "writec sol writes", nlog, 0);
    stop_prog();

    // R12 reserved bits
    clear_prog();
    imem[0] = ins(4'h1, 1, 1, 4) | 32'h0010_0000; imem[1] = 32'h100;
    push(32'h88, 1, 0);
    run_prog();
    chk("R12", "reserved dw0 irq", irq_err, 1);
    chk("R12", "reserved dw0 writes", nlog, 0);
    stop_prog();
    clear_prog();
    imem[0] = {4'h7, 28'd0}; imem[1] = 32'h0001_0005;
    run_prog();
    chk("R12", "jump upper bits irq", irq_err, 1);
    chk("R12", "jump upper fetches", nfl, 2);
    stop_prog();

    // R9 early EOL drops the rest of the line
    clear_prog();
    imem[0] = ins(4'h1, 1, 0, 16); imem[1] = 32'h4000;
    imem[2] = ins(4'h9, 0, 0, 8);
    imem[3] = ins(4'h2, 0, 0, 4);
    imem[4] = ins(4'h1, 0, 1, 4); imem[5] = 32'h5000;
    imem[6] = ins(4'h9, 0, 1, 4);
    push(32'hA1, 0, 0); push(32'hB2, 1, 0); push(32'hC3, 1, 0);
    run_prog();
    chk("R9", "early eol writes", nlog, 3);
    chk("R9", "early eol pops", fptr, 3);
    chk("R9", "eol word written", ldat[1], 32'hB2);
    chk("R9", "counter after drop", la[2], 32'h4008);
    chk("R9", "data after drop", ldat[2], 32'hC3);
    stop_prog();

    // R9 EOL on first word of an instruction marked EOL: no drop
    clear_prog();
    stall = 1;
    imem[0] = ins(4'h1, 1, 1, 8); imem[1] = 32'h4100;
    imem[2] = ins(4'h9, 0, 1, 4);
    push(32'hD1, 1, 0); push(32'hD2, 1, 0);
    run_prog();
    chk("R9", "marked eol writes", nlog, 2);
    chk("R9", "marked eol next addr", la[1], 32'h4104);
    stop_prog();

    // R5 R12 jump and fetch order
    clear_prog();
    imem[0] = {4'h7, 28'd0}; imem[1] = 32'd20;
    imem[2] = ins(4'h1, 1, 1, 4); imem[3] = 32'h8000;
    imem[20] = ins(4'h1, 1, 1, 4); imem[21] = 32'h7000;
    push(32'hE1, 1, 0);
    run_prog();
    chk("R5", "jump writes", nlog, 1);
    chk("R5", "jump target addr", la[0], 32'h7000);
    chk("R12", "fetch count", nfl, 5);
    chk("R12", "fetch 0", fl[0], 0);
    chk("R12", "fetch 1", fl[1], 1);
    chk("R5", "fetch 2", fl[2], 20);
    chk("R12", "fetch 3", fl[3], 21);
    chk("R12", "fetch 4", fl[4], 22);
    stop_prog();

    // R10 R11 error raised while clear is held
    clear_prog();
    imem[0] = 32'hF000_0000;
    push(32'h99, 1, 0);
    irq_clr = 1;
    run_prog();
    chk("R10", "set wins over clear", saw_irq, 1);
    chk("R10", "clear drops irq", irq_err, 0);
    chk("R8", "still frozen", if_req, 0);
    chk("R8", "no pops frozen", fptr, 0);
    irq_clr = 0;
    run_en = 0; repeat (2) @(negedge clk);
    imem[0] = ins(4'h1, 1, 1, 4); imem[1] = 32'h9000;
    run_prog();
    chk("R11", "restart fetch at start", fl[0], 0);
    chk("R11", "restart write", la[0], 32'h9000);
    stop_prog();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule